// File: doc/BRIEF.md
# Storage Device Power Mode Controller

This block tracks the power mode of a storage device and decides when its main clock may stop. The command decoder drives it with single-cycle event pulses: a command has arrived, a command has finished, a sleep command was decoded, a soft reset was requested, or an IDLE command supplied a new timer value. A power-on reset (`por_n`) and a synchronous hardware reset (`hw_rst`) both send it back through a short initialisation phase.

The controller reports its mode as a 3-bit code. It drives an enable for the main clock gate, and it returns the byte that a power-mode query hands back to the host. While the device sits in Idle, a timer counts down toward Sleep. The timer runs on a prescaled tick. One unit of the programmed value equals `TICKS_PER_UNIT` ticks of `PRESCALE` clock cycles each, and a programmed value of zero switches the timer off.

When the device leaves Sleep because of a command or a soft reset, it passes through a wake phase of `WAKE_CYCLES` cycles before it becomes Active. This gives the main clock time to restart. All control pins are plain levels or pulses, with no handshake.

Top module: `pm_power_ctrl`

## Requirements
- R1: `por_n` low, or `hw_rst` high at a clock edge in any state, puts the block in INIT (mode 0). It then stays in INIT for exactly `INIT_CYCLES` cycles and moves to STANDBY (mode 1).
- R2: In STANDBY or IDLE (mode 3), a `cmd_arrive` or `soft_rst` pulse moves the block to ACTIVE (mode 2) at the next edge.
- R3: In ACTIVE, `cmd_done` moves the block to IDLE at the next edge. If `cmd_arrive` or `soft_rst` is high in the same cycle, the block stays in ACTIVE.
- R4: In IDLE, `sleep_cmd` with no `cmd_arrive` or `soft_rst` moves the block to SLEEP (mode 4) at the next edge. `sleep_cmd` has no effect in any other mode.
- R5: With a nonzero timer setting S, the block leaves IDLE for SLEEP after exactly S×`TICKS_PER_UNIT`×`PRESCALE` consecutive cycles in IDLE. With S = 0 it never times out.
- R6: The timer count restarts when IDLE is entered and on every `idle_set` pulse. `idle_set` loads `idle_value` as S in any mode. Both resets clear S to 0.
- R7: In SLEEP, `cmd_arrive` or `soft_rst` moves the block to WAKE (mode 5). It holds WAKE for `WAKE_CYCLES` cycles and then enters ACTIVE. `cmd_done`, `sleep_cmd` and further commands have no effect during WAKE.
- R8: `main_clk_en` is low in SLEEP and high in every other mode.
- R9: `pm_check` is 8'hFF in ACTIVE or IDLE and 8'h00 in INIT, STANDBY, SLEEP and WAKE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock (free running) |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| hw_rst | input | 1 | Synchronous hardware reset, active high |
| soft_rst | input | 1 | Soft reset request pulse |
| cmd_arrive | input | 1 | Command-arrival pulse |
| cmd_done | input | 1 | Command or soft-reset completion pulse |
| sleep_cmd | input | 1 | Decoded sleep command pulse |
| idle_set | input | 1 | IDLE command pulse that loads the timer setting |
| idle_value | input | TIMER_W | Timer setting carried by the IDLE command |
| mode | output | 3 | Current mode code (0 INIT, 1 STANDBY, 2 ACTIVE, 3 IDLE, 4 SLEEP, 5 WAKE) |
| main_clk_en | output | 1 | Enable for the main clock gate |
| pm_check | output | 8 | Byte returned by a power-mode query |

## Verification
Every wrong state shows up on `mode` in the cycle after the edge that caused it. A broken transition is therefore seen one clock after the stimulus pulse. Errors in the timer or the hold counter hide until the window ends, and then `mode` changes one cycle early or late. For that reason the bench samples the cycle just before and just after every timeout, initialisation window and wake window. An error in the timer setting, whether a lost load, a missed clear on reset or a missed restart, shows only as a timeout at the wrong time or no timeout at all. It is checked by holding IDLE well past the point where a stale setting would have fired.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [2:0] {
    PM_INIT    = 3'd0,
    PM_STANDBY = 3'd1,
    PM_ACTIVE  = 3'd2,
    PM_IDLE    = 3'd3,
    PM_SLEEP   = 3'd4,
    PM_WAKE    = 3'd5
  } pm_state_e;

  localparam logic [7:0] PM_CHK_POWERED = 8'hFF;
  localparam logic [7:0] PM_CHK_LOW     = 8'h00;

  // Modes in which the host query reports the device as powered up
  function automatic logic pm_reports_on(input pm_state_e s);
    return (s == PM_ACTIVE) || (s == PM_IDLE);
  endfunction

  // Only the sleep mode stops the main clock
  function automatic logic pm_clock_runs(input pm_state_e s);
    return s != PM_SLEEP;
  endfunction

endpackage

// File: rtl/pm_hold_cnt.sv
// Down counter that times the initialisation and wake windows.
module pm_hold_cnt #(
  parameter int             W       = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      cnt <= RST_VAL;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/pm_idle_timer.sv
// Idle-to-sleep timeout: prescaler, tick divider and unit counter.
module pm_idle_timer #(
  parameter int PRESCALE       = 4,
  parameter int TICKS_PER_UNIT = 2,
  parameter int TIMER_W        = 8
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               hw_rst,
  input  logic               in_idle,
  input  logic               restart,
  input  logic               set_en,
  input  logic [TIMER_W-1:0] set_val,
  output logic               expire
);

  logic [TIMER_W-1:0] setting;
  logic [TIMER_W-1:0] units;
  logic               clear;
  logic               run;
  logic               pre_wrap;
  logic               unit_wrap;

  assign clear = !in_idle || restart;
  assign run   = !clear;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      setting <= '0;
    else if (hw_rst)
      setting <= '0;
    else if (set_en)
      setting <= set_val;
  end

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
          pre <= '0;
        else if (clear || pre == PRE_LAST)
          pre <= '0;
        else
          pre <= pre + PW'(1);
      end
      assign pre_wrap = run && (pre == PRE_LAST);
    end else begin : g_pre_bypass
      assign pre_wrap = run;
    end
  endgenerate

  generate
    if (TICKS_PER_UNIT > 1) begin : g_tick
      localparam int TW = $clog2(TICKS_PER_UNIT);
      localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_UNIT - 1);
      logic [TW-1:0] tk;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
          tk <= '0;
        else if (clear)
          tk <= '0;
        else if (pre_wrap)
          tk <= (tk == TICK_LAST) ? '0 : tk + TW'(1);
      end
      assign unit_wrap = pre_wrap && (tk == TICK_LAST);
    end else begin : g_tick_bypass
      assign unit_wrap = pre_wrap;
    end
  endgenerate

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      units <= '0;
    else if (clear)
      units <= '0;
    else if (unit_wrap)
      units <= units + TIMER_W'(1);
  end

  assign expire = unit_wrap && (setting != '0) &&
                  (units == setting - TIMER_W'(1));

endmodule

// File: rtl/pm_fsm.sv
// Mode sequencer: next-state logic and the state register.
module pm_fsm
  import pm_pkg::*;
#(
  parameter int                HOLD_W  = 2,
  parameter logic [HOLD_W-1:0] INIT_LD = '0,
  parameter logic [HOLD_W-1:0] WAKE_LD = '0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hw_rst,
  input  logic              soft_rst,
  input  logic              cmd_arrive,
  input  logic              cmd_done,
  input  logic              sleep_cmd,
  input  logic              timer_expire,
  input  logic              hold_zero,
  output pm_state_e         state,
  output logic              hold_load,
  output logic [HOLD_W-1:0] hold_val
);

  pm_state_e nxt;
  logic      wake_evt;

  assign wake_evt = soft_rst || cmd_arrive;

  always_comb begin
    nxt       = state;
    hold_load = 1'b0;
    hold_val  = INIT_LD;
    if (hw_rst) begin
      nxt       = PM_INIT;
      hold_load = 1'b1;
    end else begin
      case (state)
        PM_INIT:    if (hold_zero) nxt = PM_STANDBY;
        PM_STANDBY: if (wake_evt) nxt = PM_ACTIVE;
        PM_ACTIVE:  if (!wake_evt && cmd_done) nxt = PM_IDLE;
        PM_IDLE: begin
          if (wake_evt)
            nxt = PM_ACTIVE;
          else if (sleep_cmd || timer_expire)
            nxt = PM_SLEEP;
        end
        PM_SLEEP: begin
          if (wake_evt) begin
            nxt       = PM_WAKE;
            hold_load = 1'b1;
            hold_val  = WAKE_LD;
          end
        end
        PM_WAKE:    if (hold_zero) nxt = PM_ACTIVE;
        default: begin
          nxt       = PM_INIT;
          hold_load = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      state <= PM_INIT;
    else
      state <= nxt;
  end

endmodule

// File: rtl/pm_power_ctrl.sv
module pm_power_ctrl
  import pm_pkg::*;
#(
  parameter int PRESCALE       = 4,
  parameter int TICKS_PER_UNIT = 2,
  parameter int TIMER_W        = 8,
  parameter int INIT_CYCLES    = 3,
  parameter int WAKE_CYCLES    = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               hw_rst,
  input  logic               soft_rst,
  input  logic               cmd_arrive,
  input  logic               cmd_done,
  input  logic               sleep_cmd,
  input  logic               idle_set,
  input  logic [TIMER_W-1:0] idle_value,
  output logic [2:0]         mode,
  output logic               main_clk_en,
  output logic [7:0]         pm_check
);

  localparam int HOLD_MAX = (INIT_CYCLES > WAKE_CYCLES) ? INIT_CYCLES : WAKE_CYCLES;
  localparam int HOLD_W   = $clog2(HOLD_MAX + 1);
  localparam logic [HOLD_W-1:0] INIT_LD = HOLD_W'(INIT_CYCLES - 1);
  localparam logic [HOLD_W-1:0] WAKE_LD = HOLD_W'(WAKE_CYCLES - 1);

  pm_state_e         state;
  logic              hold_load;
  logic [HOLD_W-1:0] hold_val;
  logic              hold_zero;
  logic              timer_expire;
  logic              timer_restart;

  assign timer_restart = cmd_arrive || soft_rst || idle_set;

  pm_fsm #(
    .HOLD_W (HOLD_W),
    .INIT_LD(INIT_LD),
    .WAKE_LD(WAKE_LD)
  ) u_fsm (
    .clk         (clk),
    .por_n       (por_n),
    .hw_rst      (hw_rst),
    .soft_rst    (soft_rst),
    .cmd_arrive  (cmd_arrive),
    .cmd_done    (cmd_done),
    .sleep_cmd   (sleep_cmd),
    .timer_expire(timer_expire),
    .hold_zero   (hold_zero),
    .state       (state),
    .hold_load   (hold_load),
    .hold_val    (hold_val)
  );

  pm_hold_cnt #(
    .W      (HOLD_W),
    .RST_VAL(INIT_LD)
  ) u_hold (
    .clk     (clk),
    .por_n   (por_n),
    .load    (hold_load),
    .load_val(hold_val),
    .zero    (hold_zero)
  );

  pm_idle_timer #(
    .PRESCALE      (PRESCALE),
    .TICKS_PER_UNIT(TICKS_PER_UNIT),
    .TIMER_W       (TIMER_W)
  ) u_timer (
    .clk    (clk),
    .por_n  (por_n),
    .hw_rst (hw_rst),
    .in_idle(state == PM_IDLE),
    .restart(timer_restart),
    .set_en (idle_set),
    .set_val(idle_value),
    .expire (timer_expire)
  );

  assign mode        = state;
  assign main_clk_en = pm_clock_runs(state);
  assign pm_check    = pm_reports_on(state) ? PM_CHK_POWERED : PM_CHK_LOW;

endmodule

// File: rtl/pm_power_ctrl_chk.sv
module pm_power_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       hw_rst,
  input logic       soft_rst,
  input logic       cmd_arrive,
  input logic       cmd_done,
  input logic       sleep_cmd,
  input logic [2:0] mode,
  input logic       main_clk_en,
  input logic [7:0] pm_check
);

  a_r1_hw_reset: assert property (@(posedge clk) disable iff (!por_n)
    hw_rst |=> (mode == 3'd0));

  a_r2_cmd_to_active: assert property (@(posedge clk) disable iff (!por_n)
    (!hw_rst && cmd_arrive && (mode == 3'd1 || mode == 3'd3)) |=> (mode == 3'd2));

  a_r3_done_to_idle: assert property (@(posedge clk) disable iff (!por_n)
    (!hw_rst && !cmd_arrive && !soft_rst && cmd_done && mode == 3'd2) |=> (mode == 3'd3));

  a_r4_sleep_cmd: assert property (@(posedge clk) disable iff (!por_n)
    (!hw_rst && !cmd_arrive && !soft_rst && sleep_cmd && mode == 3'd3) |=> (mode == 3'd4));

  a_r7_sleep_exit: assert property (@(posedge clk) disable iff (!por_n)
    (!hw_rst && mode == 3'd4) |=> (mode == 3'd4 || mode == 3'd5));

  a_r8_gate_from_idle: assert property (@(posedge clk) disable iff (!por_n)
    $fell(main_clk_en) |-> ($past(mode) == 3'd3));

  a_r8_sleep_gated: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 3'd4) |-> !main_clk_en);

  a_r9_on_implies_clock: assert property (@(posedge clk) disable iff (!por_n)
    (pm_check == 8'hFF) |-> main_clk_en);

endmodule

bind pm_power_ctrl pm_power_ctrl_chk u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .hw_rst     (hw_rst),
  .soft_rst   (soft_rst),
  .cmd_arrive (cmd_arrive),
  .cmd_done   (cmd_done),
  .sleep_cmd  (sleep_cmd),
  .mode       (mode),
  .main_clk_en(main_clk_en),
  .pm_check   (pm_check)
);

// File: tb/tb_pm_power_ctrl.sv
module tb_pm_power_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int PRE        = 4;
  localparam int TPU        = 2;
  localparam int INIT_C     = 3;
  localparam int WAKE_C     = 2;
  localparam int M_INIT = 0, M_STBY = 1, M_ACT = 2, M_IDLE = 3, M_SLP = 4, M_WAKE = 5;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       hw_rst = 1'b0, soft_rst = 1'b0, cmd_arrive = 1'b0, cmd_done = 1'b0;
  logic       sleep_cmd = 1'b0, idle_set = 1'b0;
  logic [7:0] idle_value = 8'd0;
  logic [2:0] mode;
  logic       main_clk_en;
  logic [7:0] pm_check;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pm_power_ctrl #(
    .PRESCALE(PRE), .TICKS_PER_UNIT(TPU), .TIMER_W(8),
    .INIT_CYCLES(INIT_C), .WAKE_CYCLES(WAKE_C)
  ) dut (
    .clk(clk), .por_n(por_n), .hw_rst(hw_rst), .soft_rst(soft_rst),
    .cmd_arrive(cmd_arrive), .cmd_done(cmd_done), .sleep_cmd(sleep_cmd),
    .idle_set(idle_set), .idle_value(idle_value),
    .mode(mode), .main_clk_en(main_clk_en), .pm_check(pm_check)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Mode plus the two outputs that follow from it (R8, R9)
  task automatic chk_mode(input string req, input int exp);
    chk(req, int'(mode), exp);
    chk({req, " R8 clk_en"}, int'(main_clk_en), (exp == M_SLP) ? 0 : 1);
    chk({req, " R9 pm_check"}, int'(pm_check),
        (exp == M_ACT || exp == M_IDLE) ? 8'hFF : 8'h00);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_cmd();  cmd_arrive = 1; tick(); cmd_arrive = 0; endtask
  task automatic pulse_done(); cmd_done = 1;   tick(); cmd_done = 0;   endtask
  task automatic pulse_soft(); soft_rst = 1;   tick(); soft_rst = 0;   endtask
  task automatic pulse_sleep(); sleep_cmd = 1; tick(); sleep_cmd = 0;  endtask
  task automatic pulse_hw();   hw_rst = 1;     tick(); hw_rst = 0;     endtask
  task automatic pulse_set(input int v);
    idle_value = 8'(v); idle_set = 1; tick(); idle_set = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic t_reset();
    ticks(2);
    por_n = 1;
    chk_mode("R1 init after power-on", M_INIT);
    ticks(INIT_C - 1);
    chk_mode("R1 still init on last cycle", M_INIT);
    tick();
    chk_mode("R1 standby after init", M_STBY);
  endtask

  task automatic t_standby_ignore();
    pulse_sleep();
    chk_mode("R4 sleep_cmd ignored in standby", M_STBY);
    pulse_done();
    chk_mode("R3 cmd_done ignored in standby", M_STBY);
  endtask

  task automatic t_cmd_flow();
    pulse_cmd();
    chk_mode("R2 command from standby", M_ACT);
    cmd_arrive = 1; cmd_done = 1; tick(); cmd_arrive = 0; cmd_done = 0;
    chk_mode("R3 new command wins over done", M_ACT);
    pulse_done();
    chk_mode("R3 done moves to idle", M_IDLE);
  endtask

  task automatic t_timer_off();
    ticks(200);
    chk_mode("R5 zero setting never times out", M_IDLE);
  endtask

  task automatic t_timer_fire();
    pulse_set(3);
    chk_mode("R6 idle_set keeps idle", M_IDLE);
    ticks(3 * TPU * PRE - 1);
    chk_mode("R5 idle one cycle before timeout", M_IDLE);
    tick();
    chk_mode("R5 sleep at timeout", M_SLP);
  endtask

  task automatic t_wake();
    pulse_sleep();
    chk_mode("R4 sleep_cmd ignored in sleep", M_SLP);
    pulse_cmd();
    chk_mode("R7 command starts wake", M_WAKE);
    pulse_done();
    chk_mode("R7 cmd_done ignored in wake", M_WAKE);
    tick();
    chk_mode("R7 active after wake window", M_ACT);
  endtask

  task automatic t_restart();
    pulse_done();
    ticks(10);
    pulse_cmd();
    chk_mode("R2 command from idle", M_ACT);
    pulse_done();
    ticks(3 * TPU * PRE - 1);
    chk_mode("R6 count restarted on reentry", M_IDLE);
    tick();
    chk_mode("R6 timeout after full window", M_SLP);
    pulse_soft();
    chk_mode("R7 soft reset starts wake", M_WAKE);
    ticks(WAKE_C);
    chk_mode("R7 soft wake reaches active", M_ACT);
    pulse_done();
    ticks(10);
    pulse_set(3);
    ticks(3 * TPU * PRE - 1);
    chk_mode("R6 idle_set restarts count", M_IDLE);
    tick();
    chk_mode("R6 timeout after idle_set restart", M_SLP);
  endtask

  task automatic t_sleep_cmd();
    pulse_cmd();
    ticks(WAKE_C);
    pulse_done();
    chk_mode("R3 idle after wake and done", M_IDLE);
    ticks(5);
    pulse_sleep();
    chk_mode("R4 sleep command from idle", M_SLP);
  endtask

  task automatic t_hw_reset();
    pulse_hw();
    chk_mode("R1 hardware reset from sleep", M_INIT);
    ticks(INIT_C - 1);
    chk_mode("R1 init window after hw reset", M_INIT);
    tick();
    chk_mode("R1 standby after hw reset", M_STBY);
    pulse_soft();
    chk_mode("R2 soft reset from standby", M_ACT);
    pulse_done();
    ticks(60);
    chk_mode("R6 setting cleared by hw reset", M_IDLE);
    pulse_cmd();
    pulse_set(1);
    chk_mode("R6 idle_set in active stays active", M_ACT);
    pulse_done();
    ticks(TPU * PRE - 1);
    chk_mode("R6 setting loaded in active, before timeout", M_IDLE);
    tick();
    chk_mode("R5 one-unit timeout", M_SLP);
  endtask

  initial begin
    t_reset();
    t_standby_ignore();
    t_cmd_flow();
    t_timer_off();
    t_timer_fire();
    t_wake();
    t_restart();
    t_sleep_cmd();
    t_hw_reset();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule